// File: doc/BRIEF.md
# Predicated Vector Integer-to-Float Converter

This block turns packed signed two's-complement integers into IEEE-754 floating-point numbers across a whole vector. A per-lane predicate picks the lanes that are converted. Every other lane passes the matching lane of a supplied old destination vector through unchanged, so the caller gets merge behaviour without a second pass.

The lane width is the wider of the source integer width (32 or 64 bits) and the result format width (16, 32 or 64 bits). A narrow integer is read from the low bits of its lane. A narrow result is zero-extended up to the lane width. An optional fractional-bit count treats the integer as a fixed-point value. The caller supplies one of four rounding modes. Apart from the result vector, the block reports one flag: whether any converted lane was rounded.

Operands enter through a valid/ready handshake. The result is registered and offered one cycle after acceptance. It is held until the consumer takes it.

Top module: `i2f_vec_cvt`

## Requirements
- R1: Each converted lane holds the correctly rounded floating-point value of its signed integer. A zero input gives positive zero, and the most negative integer converts exactly to minus a power of two.
- R2: `dst_fmt` selects the result format: 2'b00 half, 2'b01 single, 2'b10 double, and 2'b11 is treated as double. `src_is64`=1 selects 64-bit source integers and 0 selects 32-bit ones.
- R3: Lanes are 64 bits wide when `src_is64`=1 or `dst_fmt[1]`=1, and 32 bits wide otherwise. Lane i occupies bits [i*W +: W] and is governed by `pred[i]`. Predicate bits above the lane count are ignored.
- R4: A lane whose predicate bit is clear outputs the corresponding bits of `old_vec` unchanged.
- R5: With a 32-bit source in a 64-bit lane, only lane bits [31:0] are converted and lane bits [63:32] of `src_vec` have no effect.
- R6: A half or single result in a wider lane sits in the low bits, and the remaining lane bits are zero.
- R7: A nonzero `frac_bits` value f scales the integer by 2^-f before rounding. Results below the smallest normal value are encoded as subnormals.
- R8: `rnd_mode` selects nearest-even (2'b00), toward plus infinity (2'b01), toward minus infinity (2'b10) or toward zero (2'b11).
- R9: A half result whose magnitude is too large becomes infinity under nearest-even, and also when rounding is directed away from zero for that sign. Under toward-zero, and when rounding is directed toward zero for that sign, it becomes the largest finite value. Either case counts as inexact.
- R10: `out_inexact` is the OR of the rounding-inexact flags of the converted lanes only. Lanes with a clear predicate never set it.
- R11: A result becomes valid on the cycle after `in_valid && in_ready`. It stays valid and stable while `out_ready` is low. `in_ready` is high exactly when no result is held or the held one is being taken.
- R12: After reset `out_valid`, `out_vec` and `out_inexact` are zero and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands offered |
| in_ready | output | 1 | Operands can be taken |
| src_vec | input | VEC_W | Packed signed integer lanes |
| old_vec | input | VEC_W | Prior destination contents, merged into inactive lanes |
| pred | input | VEC_W/32 | Per-lane predicate, bit i for lane i |
| src_is64 | input | 1 | 1: 64-bit source integers, 0: 32-bit |
| dst_fmt | input | 2 | Result format select |
| frac_bits | input | 6 | Fixed-point fractional bit count |
| rnd_mode | input | 2 | Rounding mode |
| out_valid | output | 1 | Result held |
| out_ready | input | 1 | Consumer takes the result |
| out_vec | output | VEC_W | Merged result vector |
| out_inexact | output | 1 | Some converted lane was rounded |

## Verification
On every cycle the assertions check the handshake timing and hold behaviour, the merge of inactive lane 0, the zero upper half of a half-precision lane, and that an all-clear predicate can never raise the inexact flag. The numeric value of each conversion cannot be expressed as a property. The same goes for rounding-mode differences, subnormal fixed-point results, half-precision overflow saturation and the 64-bit lane mapping, so only the bench's sweeps show them. The sweeps compare every lane against an independent rounding model across formats, modes, source sizes, fraction counts and predicate patterns.

// File: rtl/i2f_pkg.sv
package i2f_pkg;

  localparam logic [1:0] FMT_HALF   = 2'b00;
  localparam logic [1:0] FMT_SINGLE = 2'b01;

  localparam logic [1:0] RND_NEAR = 2'b00;
  localparam logic [1:0] RND_UP   = 2'b01;
  localparam logic [1:0] RND_DOWN = 2'b10;

  typedef struct packed {
    logic [63:0] bits;
    logic        inexact;
  } conv_res_t;

  // Count of leading zeros in a 64-bit word (64 for zero).
  function automatic int lead_zeros(input logic [63:0] v);
    int n;
    n = 64;
    for (int i = 0; i < 64; i++) begin
      if (v[i]) n = 63 - i;
    end
    return n;
  endfunction

  // Signed 64-bit integer, scaled by 2^-fb, to half/single/double.
  function automatic conv_res_t int_to_fp(input logic [63:0] x,
                                          input logic [5:0]  fb,
                                          input logic [1:0]  fmt,
                                          input logic [1:0]  rm);
    conv_res_t   res;
    logic        sgn, grd, stk, inc, ovf, away;
    logic [63:0] mag, nrm, keep, base, enc, top_exp;
    logic [127:0] wide;
    int          mw, ew, bias, lz, e, extra, sh;
    case (fmt)
      FMT_HALF:   begin mw = 10; ew = 5;  bias = 15;   end
      FMT_SINGLE: begin mw = 23; ew = 8;  bias = 127;  end
      default:    begin mw = 52; ew = 11; bias = 1023; end
    endcase
    res = '0;
    sgn = x[63];
    mag = sgn ? (~x + 64'd1) : x;
    if (mag != 64'd0) begin
      lz    = lead_zeros(mag);
      nrm   = mag << lz;
      e     = 63 - lz - int'(fb);
      extra = (e < 1 - bias) ? (1 - bias - e) : 0;
      sh    = 63 - mw + extra;
      if (sh > 127) sh = 127;
      wide  = {nrm, 64'd0} >> sh;
      keep  = wide[127:64];
      grd   = wide[63];
      stk   = |wide[62:0];
      case (rm)
        RND_NEAR: inc = grd & (stk | keep[0]);
        RND_UP:   inc = ~sgn & (grd | stk);
        RND_DOWN: inc = sgn & (grd | stk);
        default:  inc = 1'b0;
      endcase
      base    = (extra != 0) ? 64'd0 : 64'(e + bias - 1);
      enc     = (base << mw) + keep + {63'd0, inc};
      top_exp = ((64'd1 << ew) - 64'd1) << mw;
      ovf     = (enc >= top_exp);
      if (ovf) begin
        away = (rm == RND_NEAR) | ((rm == RND_UP) & ~sgn) | ((rm == RND_DOWN) & sgn);
        enc  = away ? top_exp : (top_exp - 64'd1);
      end
      res.bits    = enc | ({63'd0, sgn} << (mw + ew));
      res.inexact = grd | stk | ovf;
    end
    return res;
  endfunction

  // Narrow variant: only the low 32 result bits are needed.
  function automatic logic [32:0] int_to_fp32(input logic [63:0] x,
                                              input logic [5:0]  fb,
                                              input logic [1:0]  fmt,
                                              input logic [1:0]  rm);
    conv_res_t r;
    r = int_to_fp(x, fb, fmt, rm);
    return {r.inexact, r.bits[31:0]};
  endfunction

endpackage

// File: rtl/i2f_lane.sv
module i2f_lane #(
  parameter bit WIDE = 1'b1,
  localparam int OW = WIDE ? 64 : 32
) (
  input  logic [63:0]   int_in,
  input  logic [5:0]    frac_bits,
  input  logic [1:0]    fmt,
  input  logic [1:0]    rnd_mode,
  output logic [OW-1:0] fp_out,
  output logic          rounded
);
  import i2f_pkg::*;

  generate
    if (WIDE) begin : g_wide
      conv_res_t r;
      always_comb r = int_to_fp(int_in, frac_bits, fmt, rnd_mode);
      assign fp_out  = r.bits;
      assign rounded = r.inexact;
    end else begin : g_narrow
      logic [32:0] r;
      always_comb r = int_to_fp32(int_in, frac_bits, fmt, rnd_mode);
      assign fp_out  = r[31:0];
      assign rounded = r[32];
    end
  endgenerate
endmodule

// File: rtl/i2f_hold_reg.sv
module i2f_hold_reg #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         drain,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic         vld
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= 1'b0;
      q   <= '0;
    end else if (load) begin
      vld <= 1'b1;
      q   <= d;
    end else if (drain) begin
      vld <= 1'b0;
    end
  end
endmodule

// File: rtl/i2f_vec_cvt.sv
module i2f_vec_cvt #(
  parameter int VEC_W = 256,
  localparam int NSLOT = VEC_W / 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [VEC_W-1:0] src_vec,
  input  logic [VEC_W-1:0] old_vec,
  input  logic [NSLOT-1:0] pred,
  input  logic             src_is64,
  input  logic [1:0]       dst_fmt,
  input  logic [5:0]       frac_bits,
  input  logic [1:0]       rnd_mode,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [VEC_W-1:0] out_vec,
  output logic             out_inexact
);
  // Named internal events, observed by the bound checker.
  logic             take;
  logic             lane64;
  logic [NSLOT-1:0] slot_write;
  logic [NSLOT-1:0] slot_round;
  logic [VEC_W-1:0] merged;
  logic             any_round;

  assign lane64   = src_is64 | dst_fmt[1];
  assign in_ready = ~out_valid | out_ready;
  assign take     = in_valid & in_ready;

  // Each 32-bit slot owns a converter; in 64-bit lane mode the even
  // slot converts the whole lane and the odd slot carries its top half.
  logic [63:0] even_fp [NSLOT];

  genvar s;
  generate
    for (s = 0; s < NSLOT; s++) begin : g_slot
      logic [63:0] sext_in;
      logic        cv_round;
      assign sext_in = {{32{src_vec[32*s+31]}}, src_vec[32*s +: 32]};

      if (s % 2 == 0) begin : g_even
        logic [63:0] cv_in;
        logic [63:0] cv_fp;
        assign cv_in = src_is64 ? src_vec[32*s +: 64] : sext_in;
        i2f_lane #(.WIDE(1'b1)) u_cv (
          .int_in(cv_in), .frac_bits(frac_bits), .fmt(dst_fmt),
          .rnd_mode(rnd_mode), .fp_out(cv_fp), .rounded(cv_round)
        );
        assign even_fp[s]    = cv_fp;
        assign slot_write[s] = lane64 ? pred[s/2] : pred[s];
        assign slot_round[s] = slot_write[s] & cv_round;
        assign merged[32*s +: 32] = slot_write[s] ? cv_fp[31:0]
                                                  : old_vec[32*s +: 32];
      end else begin : g_odd
        logic [31:0] cv_fp;
        i2f_lane #(.WIDE(1'b0)) u_cv (
          .int_in(sext_in), .frac_bits(frac_bits), .fmt(dst_fmt),
          .rnd_mode(rnd_mode), .fp_out(cv_fp), .rounded(cv_round)
        );
        assign even_fp[s]    = '0;
        assign slot_write[s] = lane64 ? pred[(s-1)/2] : pred[s];
        assign slot_round[s] = ~lane64 & pred[s] & cv_round;
        assign merged[32*s +: 32] = ~slot_write[s] ? old_vec[32*s +: 32]
                                  : (lane64 ? even_fp[s-1][63:32] : cv_fp);
      end
    end
  endgenerate

  assign any_round = |slot_round;

  i2f_hold_reg #(.W(VEC_W + 1)) u_hold (
    .clk(clk), .rst_n(rst_n), .load(take), .drain(out_ready),
    .d({any_round, merged}), .q({out_inexact, out_vec}), .vld(out_valid)
  );
endmodule

// File: rtl/i2f_vec_cvt_chk.sv
module i2f_vec_cvt_chk #(
  parameter int VEC_W = 256,
  localparam int NSLOT = VEC_W / 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_ready,
  input logic [NSLOT-1:0] pred,
  input logic [31:0]      old_lo,
  input logic [1:0]       dst_fmt,
  input logic             out_valid,
  input logic             out_ready,
  input logic [VEC_W-1:0] out_vec,
  input logic             out_inexact,
  input logic             take,
  input logic             lane64
);
  // R11
  accept_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid);

  // R11
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_vec) && $stable(out_inexact)));

  // R11
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R4
  lane0_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !lane64 && !pred[0]) |=> (out_vec[31:0] == $past(old_lo)));

  // R6
  half_zext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !lane64 && pred[0] && dst_fmt == 2'b00) |=> (out_vec[31:16] == 16'd0));

  // R10
  idle_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && pred == '0) |=> !out_inexact);

  // R12
  reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!out_valid && !out_inexact));
endmodule

bind i2f_vec_cvt i2f_vec_cvt_chk #(.VEC_W(VEC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .pred(pred),
  .old_lo(old_vec[31:0]), .dst_fmt(dst_fmt), .out_valid(out_valid),
  .out_ready(out_ready), .out_vec(out_vec), .out_inexact(out_inexact),
  .take(take), .lane64(lane64)
);

// File: tb/sim_i2f_vec_cvt.sv
module sim_i2f_vec_cvt;
  localparam int VW = 64;
  localparam int NS = VW / 32;
  localparam time CYC = 20ns;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready, out_valid, out_ready = 1'b1, out_inexact;
  logic [VW-1:0] src_vec = '0, old_vec = '0, out_vec;
  logic [NS-1:0] pred = '0;
  logic src_is64 = 1'b0;
  logic [1:0] dst_fmt = 2'b00, rnd_mode = 2'b00;
  logic [5:0] frac_bits = '0;

  int n_chk = 0, n_bad = 0;
  logic [VW-1:0] got_vec;
  logic got_ix, got_v;

  always #(CYC/2) clk = ~clk;

  i2f_vec_cvt #(.VEC_W(VW)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .src_vec(src_vec), .old_vec(old_vec), .pred(pred), .src_is64(src_is64),
    .dst_fmt(dst_fmt), .frac_bits(frac_bits), .rnd_mode(rnd_mode),
    .out_valid(out_valid), .out_ready(out_ready), .out_vec(out_vec),
    .out_inexact(out_inexact)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Reference: quantum-based rounding with a three-way remainder compare.
  task automatic ref_cvt(input logic [63:0] x, input int fb, input logic [1:0] fmt,
                         input logic [1:0] rm, output logic [63:0] bits, output logic ix);
    int m, ex, b, len, q, sft, bexp;
    logic sgn, up, ovf, toinf;
    logic [63:0] mag, kept, rem, halfq, mant;
    m  = (fmt == 2'b00) ? 10 : (fmt == 2'b01) ? 23 : 52;
    ex = (fmt == 2'b00) ? 5  : (fmt == 2'b01) ? 8  : 11;
    b  = (1 << (ex - 1)) - 1;
    sgn = x[63];
    mag = sgn ? -x : x;
    bits = '0; ix = 1'b0;
    if (mag == 0) return;
    len = 0;
    for (int i = 0; i < 64; i++) if (mag[i]) len = i + 1;
    q = len - 1 - fb - m;
    if (q < 1 - b - m) q = 1 - b - m;
    sft = q + fb;
    rem = 0; halfq = 0;
    if (sft <= 0) kept = mag << (-sft);
    else begin
      kept  = mag >> sft;
      rem   = mag & ((64'd1 << sft) - 64'd1);
      halfq = 64'd1 << (sft - 1);
    end
    case (rm)
      2'b00:   up = (rem > halfq) || (rem == halfq && rem != 0 && kept[0]);
      2'b01:   up = (rem != 0) && !sgn;
      2'b10:   up = (rem != 0) && sgn;
      default: up = 1'b0;
    endcase
    kept = kept + 64'(up);
    if (kept == (64'd1 << (m + 1))) begin kept = kept >> 1; q++; end
    if (kept >= (64'd1 << m)) begin bexp = q + m + b; mant = kept - (64'd1 << m); end
    else begin bexp = 0; mant = kept; end
    ovf = (bexp >= (1 << ex) - 1);
    if (ovf) begin
      toinf = (rm == 2'b00) || (rm == 2'b01 && !sgn) || (rm == 2'b10 && sgn);
      bexp = toinf ? (1 << ex) - 1 : (1 << ex) - 2;
      mant = toinf ? 64'd0 : (64'd1 << m) - 64'd1;
    end
    bits = (64'(sgn) << (m + ex)) | (64'(bexp) << m) | mant;
    ix = (rem != 0) || ovf;
  endtask

  task automatic run_one(input logic [63:0] s, input logic [63:0] o, input logic [NS-1:0] p,
                         input logic s64, input logic [1:0] f, input int fb, input logic [1:0] rm);
    @(negedge clk);
    src_vec = s; old_vec = o; pred = p; src_is64 = s64; dst_fmt = f;
    frac_bits = 6'(fb); rnd_mode = rm; in_valid = 1'b1; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    got_v = out_valid; got_vec = out_vec; got_ix = out_inexact;
  endtask

  task automatic sweep_one(input logic [63:0] s, input logic [63:0] o, input logic [NS-1:0] p,
                           input logic s64, input logic [1:0] f, input int fb, input logic [1:0] rm);
    logic [63:0] r0, r1, ev; logic x0, x1, eix;
    run_one(s, o, p, s64, f, fb, rm);
    check("R11 valid after accept", 64'(got_v), 64'd1);
    if (s64 || f[1]) begin
      ref_cvt(s64 ? s : {{32{s[31]}}, s[31:0]}, fb, f, rm, r0, x0);
      ev  = p[0] ? r0 : o;
      eix = p[0] & x0;
      check(p[0] ? "R1 R3 R5 wide lane" : "R4 wide lane kept", got_vec, ev);
    end else begin
      ref_cvt({{32{s[31]}}, s[31:0]}, fb, f, rm, r0, x0);
      ref_cvt({{32{s[63]}}, s[63:32]}, fb, f, rm, r1, x1);
      ev[31:0]  = p[0] ? r0[31:0] : o[31:0];
      ev[63:32] = p[1] ? r1[31:0] : o[63:32];
      eix = (p[0] & x0) | (p[1] & x1);
      check("R1 R4 R6 R7 R8 narrow lanes", got_vec, ev);
    end
    check("R10 inexact", 64'(got_ix), 64'(eix));
  endtask

  initial begin
    logic [63:0] pats [16];
    logic [63:0] lfsr, v1;
    int fbs [4];
    int pc;
    pats = '{64'd0, 64'd1, -64'sd1, 64'd2049, 64'd2051, -64'sd2049, 64'd65504, 64'd65519,
             64'd65520, -64'sd65520, 64'h7FFF_FFFF, 64'h0000_0000_8000_0000,
             64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF,
             64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210};
    fbs = '{0, 3, 24, 63};
    lfsr = 64'hACE1_2468_1357_BDF0;
    pc = 0;

    repeat (3) @(negedge clk);
    // R12 reset state
    check("R12 out_valid in reset", 64'(out_valid), 64'd0);
    check("R12 out_vec in reset", out_vec, 64'd0);
    check("R12 in_ready in reset", 64'(in_ready), 64'd1);
    rst_n = 1'b1;

    // Directed cases with fixed expected encodings.
    run_one(64'd2049, 0, 2'b01, 0, 2'b00, 0, 2'b00);
    check("R8 half 2049 nearest-even", got_vec, 64'h0000_0000_0000_6800);
    check("R10 half 2049 inexact", 64'(got_ix), 64'd1);
    run_one(64'd2049, 0, 2'b01, 0, 2'b00, 0, 2'b01);
    check("R8 half 2049 toward +inf", got_vec, 64'h0000_0000_0000_6801);
    run_one(64'd65520, 0, 2'b01, 0, 2'b00, 0, 2'b00);
    check("R9 half overflow to inf", got_vec, 64'h0000_0000_0000_7C00);
    check("R9 overflow inexact", 64'(got_ix), 64'd1);
    run_one(64'd65520, 0, 2'b01, 0, 2'b00, 0, 2'b11);
    check("R9 half overflow toward zero", got_vec, 64'h0000_0000_0000_7BFF);
    run_one(64'h0000_0000_FFFF_FFFF, 0, 2'b01, 0, 2'b01, 0, 2'b00);
    check("R1 single of -1", got_vec, 64'h0000_0000_BF80_0000);
    run_one(64'd0, 64'hFFFF_FFFF_FFFF_FFFF, 2'b11, 0, 2'b01, 0, 2'b10);
    check("R1 zero gives +0", got_vec, 64'd0);
    run_one(64'h8000_0000_0000_0000, 0, 2'b01, 1, 2'b10, 0, 2'b00);
    check("R1 R2 most negative 64-bit", got_vec, 64'hC3E0_0000_0000_0000);
    check("R1 most negative exact", 64'(got_ix), 64'd0);
    run_one(64'd1, 0, 2'b01, 0, 2'b00, 24, 2'b00);
    check("R7 half subnormal 2^-24", got_vec, 64'h0000_0000_0000_0001);
    run_one(64'd3, 0, 2'b01, 0, 2'b01, 1, 2'b00);
    check("R7 single 3/2", got_vec, 64'h0000_0000_3FC0_0000);
    run_one(64'hDEAD_BEEF_0000_0005, 0, 2'b01, 0, 2'b10, 0, 2'b00);
    check("R5 upper source bits ignored", got_vec, 64'h4014_0000_0000_0000);
    run_one(64'h0000_0001_0000_0001, 64'h1111_1111_2222_2222, 2'b01, 0, 2'b00, 0, 2'b00);
    check("R6 half zero-extended lane0, R4 lane1 kept", got_vec, 64'h1111_1111_0000_3C00);
    run_one(64'd1, 0, 2'b01, 0, 2'b11, 0, 2'b00);
    check("R2 format 11 acts as double", got_vec, 64'h3FF0_0000_0000_0000);
    run_one(64'd1, 64'h5555_6666_7777_8888, 2'b10, 1, 2'b01, 0, 2'b00);
    check("R3 high predicate bit ignored in wide lane", got_vec, 64'h5555_6666_7777_8888);
    check("R3 R10 no inexact from idle lane", 64'(got_ix), 64'd0);

    // R11 backpressure: hold and block.
    @(negedge clk);
    src_vec = 64'd7; old_vec = 0; pred = 2'b01; src_is64 = 0; dst_fmt = 2'b01;
    frac_bits = 0; rnd_mode = 0; in_valid = 1'b1; out_ready = 1'b0;
    @(negedge clk);
    src_vec = 64'd9;
    v1 = out_vec;
    check("R11 valid under stall", 64'(out_valid), 64'd1);
    check("R11 value 7.0", v1, 64'h0000_0000_40E0_0000);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R11 held stable", out_vec, v1);
      check("R11 input blocked", 64'(in_ready), 64'd0);
    end
    in_valid = 1'b0; out_ready = 1'b1;
    @(negedge clk);
    check("R11 drained", 64'(out_valid), 64'd0);

    // Near-exhaustive sweep.
    for (int f = 0; f < 4; f++)
      for (int rm = 0; rm < 4; rm++)
        for (int s64 = 0; s64 < 2; s64++)
          for (int fi = 0; fi < 4; fi++)
            for (int pi = 0; pi < 24; pi++) begin
              lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
              v1 = (pi < 16) ? pats[pi] : lfsr;
              if (pi % 3 == 1) v1 = {v1[31:0], lfsr[31:0]};
              pc++;
              sweep_one(v1, ~lfsr, 2'(pc), 1'(s64), 2'(f), fbs[fi], 2'(rm));
            end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CYC * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule